// File: doc/BRIEF.md
# DRAM Refresh and Start-up Controller

This block keeps an asynchronous DRAM alive. It brings the memory through its power-up sequence: a start-up hold of at least 200 µs, then eight warm-up refresh cycles. After that it keeps every one of the 2048 rows refreshed within 32 ms by spreading one refresh over each 1/2048 of that period. Every refresh is a CAS-before-RAS cycle, so the memory's own row counter picks the row, and the address bus and output enable are left alone.

The controller shares the strobes with an access sequencer. When it needs a cycle it raises a request. When the sequencer returns a grant, the controller takes the bus, drives the strobe pattern itself and then hands the bus back. A refresh that falls due while the bus is held elsewhere is counted as pending and served later. The pending count saturates. A sticky overrun flag marks any due that arrives while two or more refreshes are already waiting. A ready flag tells the rest of the memory path when normal accesses may begin.

All timing limits are given in nanoseconds or microseconds and turned into clock counts from the clock frequency parameter. With the default 50 MHz clock:

| Quantity | Clock cycles |
|---|---|
| Start-up hold | 10000 |
| Refresh interval | 781 |
| CAS lead before RAS falls | 1 |
| RAS low | 3 |
| Recovery after RAS rises | 2 |

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is asserted and just after it, ras_n, cas_n and we_n are high, and ref_req, bus_own, ready and overrun are low.
- R2: ref_req stays low during the start-up hold. It rises for the first time exactly CLK_MHZ*INIT_US clock edges after reset is released (10000 at defaults).
- R3: In every refresh cycle, cas_n falls a lead of ceil(T_CSR_NS*CLK_MHZ/1000) cycles before ras_n falls, with ras_n high at the moment cas_n falls. cas_n stays low for as long as ras_n is low.
- R4: ras_n stays low for ceil(T_RAS_NS*CLK_MHZ/1000) cycles. Both strobes are then high for max(ceil(T_RP_NS*CLK_MHZ/1000), ceil(T_RC_NS*CLK_MHZ/1000) minus the RAS-low count) cycles before bus_own drops.
- R5: we_n is high at all times, so no refresh can be taken as a test-mode entry.
- R6: A refresh starts only on a clock edge where ref_req and ref_gnt are both high. In the cycle after that edge, bus_own is high and cas_n is low. While ref_gnt is held low, bus_own stays low.
- R7: ready rises when the INIT_REFS-th warm-up refresh (eight at defaults) completes, and it stays high until reset.
- R8: Once ready is high, a refresh falls due every CLK_MHZ*REF_MS*1000/ROWS cycles (781 at defaults). With the grant always high, successive rises of ref_req are that far apart.
- R9: Refreshes that fall due while the grant is withheld are kept as a pending count. The count saturates at 2^PEND_W-1 (7 at defaults). Once the grant returns, each pending refresh is served, back to back.
- R10: overrun is set when a refresh falls due while OVR_LEVEL (2) or more are already pending. Once set, it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_MHZ MHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_gnt | input | 1 | Access sequencer grants the bus to the controller |
| ref_req | output | 1 | Controller asks for the bus to run a refresh |
| bus_own | output | 1 | Controller is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| ready | output | 1 | Start-up sequence complete; normal accesses allowed |
| overrun | output | 1 | Sticky flag: refresh backlog reached its limit |

## Verification
The bench runs four grant patterns.

1. **Grant always high.** This covers both the warm-up burst and steady running. It pins down the hold length, the strobe order and the spacing of the dues.
2. **Grant withheld across two dues.** This shows that dues are queued rather than lost. It also shows that exactly two waiting refreshes do not yet trip the overrun flag.
3. **Grant withheld across nine dues.** This separates a saturating pending count from a wrapping one, because only seven back-to-back refreshes may follow the release. It also forces the overrun flag on and checks that the flag stays on afterwards.
4. **Cycle-by-cycle comparison.** A behavioural model runs alongside all of the above and checks every strobe and flag on every cycle.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [1:0] {
        PH_HOLD = 2'd0,
        PH_WARM = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CAS  = 2'd1,
        SQ_RAS  = 2'd2,
        SQ_RCV  = 2'd3
    } seq_e;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int ns2cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_tick.sv
module rfsh_tick #(
    parameter int PERIOD = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(PERIOD + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = en && (st_q.cnt == CW'(PERIOD - 1));
        if (!en) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // The count never goes past the last slot of the period.
    p_tick_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(PERIOD - 1))
        else $error("tick counter beyond period");

endmodule

// File: rtl/rfsh_cbr_seq.sv
module rfsh_cbr_seq
    import dram_rfsh_pkg::*;
#(
    parameter int CSR_CYC = 1,
    parameter int RAS_CYC = 3,
    parameter int RP_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic ras_n,
    output logic cas_n
);
    localparam int MAXC = imax(CSR_CYC, imax(RAS_CYC, RP_CYC));
    localparam int CW   = $clog2(MAXC + 1);
    localparam int RW   = $clog2(MAXC + 1) + 1;

    typedef struct packed {
        seq_e          st;
        logic [CW-1:0] cnt;
        logic          ras_n;
        logic          cas_n;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        unique case (st_q.st)
            SQ_IDLE: begin
                if (start) begin
                    st_d.st    = SQ_CAS;
                    st_d.cnt   = '0;
                    st_d.cas_n = 1'b0;
                end
            end
            SQ_CAS: begin
                if (st_q.cnt == CW'(CSR_CYC - 1)) begin
                    st_d.st    = SQ_RAS;
                    st_d.cnt   = '0;
                    st_d.ras_n = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            SQ_RAS: begin
                if (st_q.cnt == CW'(RAS_CYC - 1)) begin
                    st_d.st    = SQ_RCV;
                    st_d.cnt   = '0;
                    st_d.ras_n = 1'b1;
                    st_d.cas_n = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            SQ_RCV: begin
                if (st_q.cnt == CW'(RP_CYC - 1)) begin
                    done     = 1'b1;
                    st_d.st  = SQ_IDLE;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d = '{st: SQ_IDLE, cnt: '0, ras_n: 1'b1, cas_n: 1'b1};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: SQ_IDLE, cnt: '0, ras_n: 1'b1, cas_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy  = (st_q.st != SQ_IDLE);
    assign ras_n = st_q.ras_n;
    assign cas_n = st_q.cas_n;

    // Run-length counters used only by the checks below.
    logic [RW-1:0] low_run_q, high_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q  <= '0;
            high_run_q <= '0;
        end else begin
            low_run_q  <= ras_n ? '0 : ((&low_run_q)  ? low_run_q  : low_run_q  + 1'b1);
            high_run_q <= !ras_n ? '0 : ((&high_run_q) ? high_run_q : high_run_q + 1'b1);
        end
    end

    p_cas_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n))
        else $error("RAS fell without CAS already low");

    p_cas_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n)
        else $error("CAS released while RAS low");

    p_ras_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_run_q >= RW'(RAS_CYC)))
        else $error("RAS low pulse too short");

    p_rp_before_cas_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> (ras_n && (high_run_q >= RW'(RP_CYC))))
        else $error("CAS fell before RAS precharge done");

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
    import dram_rfsh_pkg::*;
#(
    parameter int CLK_MHZ   = 50,
    parameter int INIT_US   = 200,
    parameter int INIT_REFS = 8,
    parameter int ROWS      = 2048,
    parameter int REF_MS    = 32,
    parameter int PEND_W    = 3,
    parameter int OVR_LEVEL = 2,
    parameter int T_CSR_NS  = 10,
    parameter int T_RAS_NS  = 50,
    parameter int T_RP_NS   = 30,
    parameter int T_RC_NS   = 90
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    output logic ref_req,
    output logic bus_own,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic ready,
    output logic overrun
);
    localparam int HOLD_CYC = CLK_MHZ * INIT_US;
    localparam int INT_CYC  = (CLK_MHZ * REF_MS * 1000) / ROWS;
    localparam int CSR_CYC  = ns2cyc(T_CSR_NS, CLK_MHZ);
    localparam int RAS_CYC  = ns2cyc(T_RAS_NS, CLK_MHZ);
    localparam int RP_CYC   = imax(ns2cyc(T_RP_NS, CLK_MHZ),
                                   ns2cyc(T_RC_NS, CLK_MHZ) - RAS_CYC);
    localparam int WARM_W   = $clog2(INIT_REFS + 1);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    typedef struct packed {
        phase_e            phase;
        logic [WARM_W-1:0] warm;
        logic [PEND_W-1:0] pend;
        logic              ovr;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic hold_tick, run_tick, seq_busy, seq_done, start, want;

    rfsh_tick #(.PERIOD(HOLD_CYC)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (st_q.phase == PH_HOLD),
        .tick (hold_tick)
    );

    rfsh_tick #(.PERIOD(INT_CYC)) u_interval (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (st_q.phase == PH_RUN),
        .tick (run_tick)
    );

    rfsh_cbr_seq #(.CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .busy (seq_busy),
        .done (seq_done),
        .ras_n(ras_n),
        .cas_n(cas_n)
    );

    always_comb begin
        st_d  = st_q;
        want  = ((st_q.phase == PH_WARM) && (st_q.warm != '0)) ||
                ((st_q.phase == PH_RUN)  && (st_q.pend != '0));
        ref_req = want && !seq_busy;
        start   = ref_req && ref_gnt;
        unique case (st_q.phase)
            PH_HOLD: begin
                if (hold_tick) begin
                    st_d.phase = PH_WARM;
                    st_d.warm  = WARM_W'(INIT_REFS);
                end
            end
            PH_WARM: begin
                if (seq_done) begin
                    st_d.warm = st_q.warm - 1'b1;
                    if (st_q.warm == WARM_W'(1)) begin
                        st_d.phase = PH_RUN;
                    end
                end
            end
            PH_RUN: begin
                if (run_tick && !seq_done && (st_q.pend != PEND_MAX)) begin
                    st_d.pend = st_q.pend + 1'b1;
                end else if (seq_done && !run_tick) begin
                    st_d.pend = st_q.pend - 1'b1;
                end
                if (run_tick && (st_q.pend >= PEND_W'(OVR_LEVEL))) begin
                    st_d.ovr = 1'b1;
                end
            end
            default: st_d.phase = PH_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_HOLD, warm: '0, pend: '0, ovr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_own = seq_busy;
    assign we_n    = 1'b1;
    assign ready   = (st_q.phase == PH_RUN);
    assign overrun = st_q.ovr;

    p_no_req_in_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_HOLD) |-> (!ref_req && !bus_own))
        else $error("refresh requested during start-up hold");

    p_start_needs_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_own) |-> $past(ref_gnt && ref_req))
        else $error("bus taken without grant");

    p_ready_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready)
        else $error("ready dropped");

    p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun)
        else $error("overrun cleared");

    p_strobe_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n || !ras_n) |-> bus_own)
        else $error("strobe active without bus ownership");

endmodule

// File: tb/sim_dram_refresh_ctrl.sv
`timescale 1ns/1ps
module sim_dram_refresh_ctrl;

    localparam int HOLD = 50 * 200;
    localparam int INTV = (50 * 32 * 1000) / 2048;
    localparam int CSR  = 1;
    localparam int RASC = 3;
    localparam int RP   = 2;
    localparam int LEN  = CSR + RASC + RP;
    localparam int PMAX = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_gnt = 1'b1;
    logic ref_req, bus_own, ras_n, cas_n, we_n, ready, overrun;

    always #10 clk = ~clk;

    dram_refresh_ctrl u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_gnt(ref_gnt),
        .ref_req(ref_req),
        .bus_own(bus_own),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .ready  (ready),
        .overrun(overrun)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ph = 0, m_h = 0, m_w = 0, m_p = 0, m_t = 0, m_pos = -1, m_dues = 0;
    bit m_ovr = 0;
    bit b_busy, b_want, b_start, b_done, b_tick;

    function automatic bit model_want();
        return (m_ph == 1 && m_w > 0) || (m_ph == 2 && m_p > 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_h = 0; m_w = 0; m_p = 0; m_t = 0; m_pos = -1; m_ovr = 0;
        end else begin
            b_busy  = (m_pos >= 0);
            b_want  = model_want();
            b_start = b_want && !b_busy && ref_gnt;
            b_done  = b_busy && (m_pos == LEN - 1);
            b_tick  = (m_ph == 2) && (m_t == INTV - 1);
            if (b_start) m_pos = 0;
            else if (b_done) m_pos = -1;
            else if (b_busy) m_pos = m_pos + 1;
            case (m_ph)
                0: if (m_h == HOLD - 1) begin m_ph = 1; m_w = 8; m_h = 0; end
                   else m_h = m_h + 1;
                1: if (b_done) begin
                       m_w = m_w - 1;
                       if (m_w == 0) begin m_ph = 2; m_t = 0; end
                   end
                default: begin
                    if (b_tick && m_p >= 2) m_ovr = 1;
                    if (b_tick && !b_done && m_p < PMAX) m_p = m_p + 1;
                    else if (b_done && !b_tick) m_p = m_p - 1;
                    m_t = b_tick ? 0 : m_t + 1;
                    if (b_tick) m_dues = m_dues + 1;
                end
            endcase
        end
    end

    // ---------------- per-cycle comparison and event monitors ----------------
    int cyc = 0, ras_falls = 0, we_low = 0, order_bad = 0, width_bad = 0, own_nogrant = 0;
    int low_run = 0;
    logic ras_prev = 1'b1, cas_prev = 1'b1;

    always @(negedge clk) begin
        bit e_busy, e_cas, e_ras;
        cyc++;
        e_busy = (m_pos >= 0);
        e_cas  = !(m_pos >= 0 && m_pos < CSR + RASC);
        e_ras  = !(m_pos >= CSR && m_pos < CSR + RASC);
        if (!finished) begin
            chk(ras_n == e_ras && cas_n == e_cas, "R3 strobes", {ras_n, cas_n}, {e_ras, e_cas});
            chk(we_n == 1'b1, "R5 we_n", we_n, 1);
            chk(ref_req == (model_want() && !e_busy), "R6 ref_req", ref_req, model_want() && !e_busy);
            chk(bus_own == e_busy, "R6 bus_own", bus_own, e_busy);
            chk(ready == (m_ph == 2), "R7 ready", ready, m_ph == 2);
            chk(overrun == m_ovr, "R10 overrun", overrun, m_ovr);
        end
        if (!we_n) we_low++;
        if (ras_prev && !ras_n) begin
            ras_falls++;
            if (cas_prev || cas_n) order_bad++;
        end
        if (cas_prev && !cas_n && !ras_n) order_bad++;
        if (!ras_n) low_run++;
        else begin
            if (!ras_prev && low_run != RASC) width_bad++;
            low_run = 0;
        end
        if (!ref_gnt && bus_own && !$past(bus_own)) own_nogrant++;
        ras_prev = ras_n;
        cas_prev = cas_n;
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        int n, t0, f0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ras_n && cas_n && we_n, "R1 strobes high", {ras_n, cas_n, we_n}, 7);
        chk(!ref_req && !bus_own && !ready && !overrun, "R1 flags low",
            {ref_req, bus_own, ready, overrun}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ras_n && cas_n && !ref_req && !ready, "R1 after release",
            {ras_n, cas_n, ref_req, ready}, 4'b1100);

        // R2 start-up hold length
        n = 1;
        while (!ref_req && n < HOLD + 10) begin @(negedge clk); n++; end
        chk(n == HOLD, "R2 first request edge", n, HOLD);

        // R7 warm-up burst then ready
        f0 = ras_falls;
        while (!ready && n < HOLD + 500) begin @(negedge clk); n++; end
        chk(ready == 1'b1, "R7 ready reached", ready, 1);
        chk(ras_falls - f0 == 8, "R7 warm-up refresh count", ras_falls - f0, 8);

        // R8 refresh spacing
        while (!ref_req) @(negedge clk);
        t0 = cyc;
        while (ref_req) @(negedge clk);
        while (!ref_req) @(negedge clk);
        chk(cyc - t0 == INTV, "R8 due spacing", cyc - t0, INTV);
        repeat (20) @(negedge clk);
        chk(!ref_req && !bus_own, "R6 idle after served", {ref_req, bus_own}, 0);

        // R9 / R10 two withheld dues
        ref_gnt = 1'b0;
        n = m_dues + 2;
        while (m_dues < n) @(negedge clk);
        @(negedge clk);
        chk(ref_req == 1'b1, "R9 request held while withheld", ref_req, 1);
        chk(overrun == 1'b0, "R10 no overrun at two pending", overrun, 0);
        chk(own_nogrant == 0, "R6 no ownership without grant", own_nogrant, 0);
        f0 = ras_falls;
        ref_gnt = 1'b1;
        repeat (40) @(negedge clk);
        chk(ras_falls - f0 == 2, "R9 two queued refreshes served", ras_falls - f0, 2);

        // R9 saturation and R10 overrun
        ref_gnt = 1'b0;
        n = m_dues + 9;
        while (m_dues < n) @(negedge clk);
        @(negedge clk);
        chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
        f0 = ras_falls;
        ref_gnt = 1'b1;
        repeat (100) @(negedge clk);
        chk(ras_falls - f0 == PMAX, "R9 saturated backlog served", ras_falls - f0, PMAX);
        chk(overrun == 1'b1, "R10 overrun sticky", overrun, 1);

        // R3 R4 R5 strobe-shape summaries
        chk(order_bad == 0, "R3 CAS-before-RAS order", order_bad, 0);
        chk(width_bad == 0, "R4 RAS low width", width_bad, 0);
        chk(we_low == 0, "R5 we_n never low", we_low, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule